// File: doc/BRIEF.md
# Dual-Mode Programmable Clock Divider

This block is one stage of a clock generator. It takes the source clock it runs on and produces a divided clock for downstream logic. A single 8-bit divider field is read in one of two ways. In power-of-two mode the field is an exponent, and the output period is 2^(field+1) source cycles. In integer mode the field is the divisor itself. An optional half-cycle correction term evens out the duty cycle of odd integer divisors.

Divider and mode changes are taken up only at the start of the next output period, so a reconfiguration never cuts a period short. Clearing the enable, or entering standby without the keep-running control, lets the current period finish before generation stops. A busy flag stays high until the output has actually halted. While the generator is stopped the output rests at a programmable idle level. A separate pin output carries the generated clock only when the pin is enabled.

Top module: `clkdiv_gen`

## Requirements
- R1: With `cfg_pow2`=1 and `cfg_div`=D (D at most 15), `gen_clk` has a period of 2^(D+1) source cycles and is high for the first half of it.
- R2: With `cfg_pow2`=1 and `cfg_div` above 15, the period saturates at 2^16 source cycles, high for 2^15 of them.
- R3: With `cfg_pow2`=0 and `cfg_div`=N (N at least 2), the period is N source cycles. Each period starts with a rising edge on a source rising edge. For even N the output is high for N/2 cycles.
- R4: With `cfg_pow2`=0 and `cfg_div` equal to 0 or 1, `gen_clk` follows the source clock: high during the first half of each source cycle and low during the second half.
- R5: For an odd integer divisor N≥3, `gen_clk` is high for (N-1)/2 source cycles when `cfg_duty_fix`=0. When `cfg_duty_fix`=1 it is high for N/2 source cycles, extended by a falling-edge term.
- R6: A change of divider, mode or duty correction made during a period does not alter that period. It applies from the next rising edge of `gen_clk`.
- R7: After the run request is withdrawn, `gen_busy` stays 1 until the current period has ended. Generation stops at the period boundary, and `gen_busy` reads 0 from that source edge on. For divisor N≥2, withdrawn during the first source cycle of a period, that is N-1 more source cycles.
- R8: While `gen_busy`=0, including right after reset, `gen_clk` equals `cfg_idle_hi`.
- R9: The run request is `cfg_en` AND (NOT `stby_req` OR `cfg_keep_in_stby`). Standby without keep-running stops the output as in R7. With keep-running set, generation continues.
- R10: `pin_clk` equals `gen_clk` when `cfg_pin_en`=1 and is 0 when `cfg_pin_en`=0.
- R11: When stopped and the run request is present, `gen_busy` rises at the next source edge. That edge starts a period with a rising edge on `gen_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Generator enable |
| cfg_pow2 | input | 1 | 1: exponent mode, 0: integer mode |
| cfg_div | input | 8 | Divider field |
| cfg_duty_fix | input | 1 | Half-cycle duty correction for odd integer divisors |
| cfg_idle_hi | input | 1 | Output level while stopped |
| cfg_pin_en | input | 1 | Route generated clock to pin output |
| cfg_keep_in_stby | input | 1 | Keep running while standby is requested |
| stby_req | input | 1 | Standby request |
| gen_clk | output | 1 | Generated clock |
| pin_clk | output | 1 | Pin copy of the generated clock |
| gen_busy | output | 1 | Generator running; clears only once halted |

## Verification
The bench samples the output twice per source cycle and measures high time and period in half-cycles. This exposes a missing or misplaced falling-edge term: odd divisors with correction would then show N-1 rather than N half-cycles of high time. It reprograms the divider partway through a high phase. A design that loads the new value at once would produce a truncated period instead of finishing the old one. It withdraws the enable mid-period and counts the samples at which the busy flag stays high, which catches a flag that drops early or a generator that runs an extra cycle. It also checks the exponent saturation at 2^16 against an unsaturated wrap, and it checks standby with and without keep-running.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // width of the divider field
    parameter int DIV_W   = 8;
    // largest exponent honoured in power-of-two mode
    parameter int EXP_CAP = 15;
    // counter width able to hold the largest divisor 2^(EXP_CAP+1)
    localparam int CNT_W  = EXP_CAP + 2;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    // decoded ratio used by the period sequencer
    typedef struct packed {
        logic [CNT_W-1:0] n;      // source cycles per output period
        logic             fix;    // apply half-cycle extension
    } ratio_t;

    // divisor implied by mode and field
    function automatic logic [CNT_W-1:0] ratio_of(
        input logic             pow2,
        input logic [DIV_W-1:0] div
    );
        logic [CNT_W-1:0] one;
        int unsigned      e;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        if (pow2) begin
            e = (int'(div) > EXP_CAP) ? EXP_CAP : int'(div);
            return one << (e + 1);
        end
        if (div <= 1) begin
            return one;
        end
        return CNT_W'(div);
    endfunction

endpackage

// File: rtl/clkdiv_ratio.sv
`timescale 1ns/1ps
module clkdiv_ratio
    import clkdiv_pkg::*;
(
    input  logic             pow2,
    input  logic [DIV_W-1:0] div,
    input  logic             duty_fix,
    output ratio_t           ratio
);
    logic [CNT_W-1:0] n_dec;
    logic             odd_multi;

    always_comb begin
        n_dec     = ratio_of(pow2, div);
        // extension only matters for odd divisors of three or more
        odd_multi = n_dec[0] && (n_dec > {{(CNT_W-1){1'b0}}, 1'b1});
        ratio.n   = n_dec;
        ratio.fix = duty_fix && odd_multi;
    end
endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run_req,
    input  ratio_t ratio_new,
    output logic   running,
    output logic   hi_phase,
    output logic   at_last,
    output ratio_t ratio_act
);
    gen_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] half_n;
    logic             new_is_multi;

    always_comb begin
        cnt_inc      = cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        half_n       = ratio_act.n >> 1;
        at_last      = (cnt_inc == ratio_act.n);
        new_is_multi = (ratio_new.n != {{(CNT_W-1){1'b0}}, 1'b1});
        running      = (state == GEN_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= GEN_IDLE;
            cnt       <= '0;
            hi_phase  <= 1'b0;
            ratio_act <= '{n: {{(CNT_W-1){1'b0}}, 1'b1}, fix: 1'b0};
        end else begin
            case (state)
                GEN_IDLE: begin
                    if (run_req) begin
                        state     <= GEN_RUN;
                        cnt       <= '0;
                        ratio_act <= ratio_new;
                        hi_phase  <= new_is_multi;
                    end
                end
                GEN_RUN: begin
                    if (at_last) begin
                        // period boundary: stop or take up new ratio
                        cnt <= '0;
                        if (!run_req) begin
                            state    <= GEN_IDLE;
                            hi_phase <= 1'b0;
                        end else begin
                            ratio_act <= ratio_new;
                            hi_phase  <= new_is_multi;
                        end
                    end else begin
                        cnt      <= cnt_inc;
                        hi_phase <= (cnt_inc < half_n);
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clkdiv_halfstep.sv
`timescale 1ns/1ps
module clkdiv_halfstep (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // copy of the high phase delayed by half a source cycle
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/clkdiv_gen.sv
`timescale 1ns/1ps
module clkdiv_gen
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_pow2,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_duty_fix,
    input  logic             cfg_idle_hi,
    input  logic             cfg_pin_en,
    input  logic             cfg_keep_in_stby,
    input  logic             stby_req,
    output logic             gen_clk,
    output logic             pin_clk,
    output logic             gen_busy
);
    ratio_t ratio_new;
    ratio_t ratio_act;
    logic   run_req;
    logic   running;
    logic   hi_phase;
    logic   hi_late;
    logic   at_last;
    logic   bypass;

    assign run_req = cfg_en && (!stby_req || cfg_keep_in_stby);

    clkdiv_ratio u_ratio (
        .pow2     (cfg_pow2),
        .div      (cfg_div),
        .duty_fix (cfg_duty_fix),
        .ratio    (ratio_new)
    );

    clkdiv_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_req   (run_req),
        .ratio_new (ratio_new),
        .running   (running),
        .hi_phase  (hi_phase),
        .at_last   (at_last),
        .ratio_act (ratio_act)
    );

    clkdiv_halfstep u_half (
        .clk (clk),
        .rst (rst),
        .d   (hi_phase),
        .q   (hi_late)
    );

    always_comb begin
        bypass = (ratio_act.n == {{(CNT_W-1){1'b0}}, 1'b1});
        if (!running) begin
            gen_clk = cfg_idle_hi;
        end else if (bypass) begin
            gen_clk = clk;
        end else begin
            gen_clk = hi_phase || (ratio_act.fix && hi_late);
        end
        pin_clk  = cfg_pin_en && gen_clk;
        gen_busy = running;
    end
endmodule

// File: rtl/clkdiv_gen_chk.sv
`timescale 1ns/1ps
module clkdiv_gen_chk
    import clkdiv_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         cfg_en,
    input logic         cfg_idle_hi,
    input logic         cfg_pin_en,
    input logic         cfg_keep_in_stby,
    input logic         stby_req,
    input logic         gen_clk,
    input logic         pin_clk,
    input logic         gen_busy,
    input logic         at_last,
    input logic [CNT_W-1:0] act_n
);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(gen_busy) |-> $past(!(cfg_en && (!stby_req || cfg_keep_in_stby)) && at_last));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_busy |-> (gen_clk == cfg_idle_hi));

    // R10
    pin_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_pin_en |-> !pin_clk);

    // R11
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!gen_busy && cfg_en && (!stby_req || cfg_keep_in_stby)) |=> gen_busy);

    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_busy && $past(gen_busy) && !$past(at_last)) |-> $stable(act_n));
endmodule

bind clkdiv_gen clkdiv_gen_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .cfg_en           (cfg_en),
    .cfg_idle_hi      (cfg_idle_hi),
    .cfg_pin_en       (cfg_pin_en),
    .cfg_keep_in_stby (cfg_keep_in_stby),
    .stby_req         (stby_req),
    .gen_clk          (gen_clk),
    .pin_clk          (pin_clk),
    .gen_busy         (gen_busy),
    .at_last          (at_last),
    .act_n            (ratio_act.n)
);

// File: tb/clkdiv_gen_test.sv
`timescale 1ns/1ps
module clkdiv_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 0, cfg_pow2 = 0, cfg_duty_fix = 0, cfg_idle_hi = 0;
    logic       cfg_pin_en = 0, cfg_keep_in_stby = 0, stby_req = 0;
    logic [7:0] cfg_div = 0;
    logic       gen_clk, pin_clk, gen_busy;

    int  n_run = 0, n_fail = 0, cycles = 0;
    bit  done = 0;
    bit  ph = 0;
    logic cur_v = 0, prev_v = 0, cur_busy = 0, cur_pin = 0;

    clkdiv_gen uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_pow2(cfg_pow2),
        .cfg_div(cfg_div), .cfg_duty_fix(cfg_duty_fix), .cfg_idle_hi(cfg_idle_hi),
        .cfg_pin_en(cfg_pin_en), .cfg_keep_in_stby(cfg_keep_in_stby),
        .stby_req(stby_req), .gen_clk(gen_clk), .pin_clk(pin_clk), .gen_busy(gen_busy)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 190000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic int exp_n(input logic pow2, input int div);
        if (pow2) return 1 << (((div > 15) ? 15 : div) + 1);
        return (div <= 1) ? 1 : div;
    endfunction

    // high time in half source cycles
    function automatic int exp_hi(input int n, input logic fix);
        if (n == 1) return 1;
        if (n % 2 == 0) return n;
        return fix ? n : n - 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one sample per half source cycle, at a quarter period past each edge
    task automatic half();
        if (!ph) begin
            @(posedge clk);
            #2.5;
        end else begin
            #5;
        end
        ph = ~ph;
        prev_v   = cur_v;
        cur_v    = gen_clk;
        cur_busy = gen_busy;
        cur_pin  = pin_clk;
    endtask

    task automatic wait_rise();
        do half(); while (!(cur_v && !prev_v));
    endtask

    task automatic measure(output int hi, output int per);
        wait_rise();
        hi = 1;
        half();
        while (cur_v) begin hi++; half(); end
        per = hi + 1;
        half();
        while (!cur_v) begin per++; half(); end
    endtask

    task automatic set_cfg(input logic pow2, input int div, input logic fix);
        cfg_pow2 = pow2;
        cfg_div = 8'(div);
        cfg_duty_fix = fix;
    endtask

    task automatic run_case(input string req, input logic pow2, input int div, input logic fix);
        int hi, per, n;
        set_cfg(pow2, div, fix);
        wait_rise();
        measure(hi, per);
        n = exp_n(pow2, div);
        check({req, " period"}, per, 2 * n);
        check({req, " high"}, hi, exp_hi(n, fix));
    endtask

    initial begin
        int hi, per, cnt;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2.5 rst = 1'b0;
        ph = 1;
        half(); half();
        // R8: reset state
        check("R8 reset busy", int'(cur_busy), 0);
        check("R8 reset idle", int'(cur_v), 0);
        cfg_idle_hi = 1;
        half(); half();
        check("R8 idle high", int'(cur_v), 1);
        cfg_idle_hi = 0;

        // R11: start
        set_cfg(0, 4, 0);
        cfg_en = 1;
        half();
        half();
        check("R11 busy after start", int'(cur_busy), 1);
        check("R11 first rise", int'(cur_v && !prev_v), 1);

        run_case("R3 int 4", 0, 4, 0);
        run_case("R3 int 10", 0, 10, 0);
        run_case("R1 exp 0", 1, 0, 0);
        run_case("R1 exp 3", 1, 3, 0);
        run_case("R4 div 0", 0, 0, 0);
        run_case("R4 div 1", 0, 1, 1);
        run_case("R5 odd 5 nofix", 0, 5, 0);
        run_case("R5 odd 5 fix", 0, 5, 1);
        run_case("R5 odd 3 fix", 0, 3, 1);

        // R6: change mid-period keeps the old one whole
        set_cfg(0, 4, 0);
        wait_rise();
        wait_rise();
        half();
        set_cfg(0, 6, 0);
        cnt = 2;
        half();
        while (!(cur_v && !prev_v)) begin cnt++; half(); end
        check("R6 old period kept", cnt, 8);
        measure(hi, per);
        check("R6 new period", per, 12);

        // R10: pin routing
        cfg_pin_en = 0;
        cnt = 0;
        for (int i = 0; i < 24; i++) begin half(); if (cur_pin) cnt++; end
        check("R10 pin off", cnt, 0);
        cfg_pin_en = 1;
        cnt = 0;
        for (int i = 0; i < 24; i++) begin half(); if (cur_pin != cur_v) cnt++; end
        check("R10 pin follows", cnt, 0);

        // R9: standby with keep-running continues
        cfg_keep_in_stby = 1;
        stby_req = 1;
        measure(hi, per);
        check("R9 keep running period", per, 12);

        // R7: disable mid-period, divisor 5
        set_cfg(0, 5, 0);
        cfg_idle_hi = 1;
        wait_rise();
        wait_rise();
        half();
        cfg_en = 0;
        cnt = 0;
        half();
        while (cur_busy) begin cnt++; half(); end
        check("R7 busy held", cnt, 8);
        check("R8 idle after stop", int'(cur_v), 1);
        cfg_idle_hi = 0;

        // R9: standby without keep stops
        cfg_en = 1;
        cfg_keep_in_stby = 0;
        half(); half();
        check("R9 stby stopped", int'(cur_busy), 0);
        stby_req = 0;
        half(); half();
        check("R9 resume", int'(cur_busy), 1);

        // random reconfiguration
        for (int k = 0; k < 30; k++) begin
            logic p;
            int d;
            p = 1'($urandom_range(0, 1));
            d = p ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 12));
            run_case(p ? "R1 rand" : "R3 R5 rand", p, d, 1'($urandom_range(0, 1)));
        end

        // R2: saturation, exponent field 15 and 200 both give 2^16
        set_cfg(1, 200, 0);
        cfg_en = 0;
        while (cur_busy) half();
        cfg_en = 1;
        measure(hi, per);
        check("R2 sat high", hi, 65536);
        check("R2 sat period", per, 131072);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule